// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel, 12-bit converter. A host drives a parallel bus: a 12-bit code in natural binary (bit 11 most significant), a channel-select bit, an active-low chip select, one active-low load strobe per channel, an active-low reset and a reset-preset select. Each channel keeps two register stages. The staging register takes the code from the bus while chip select is low. The output register passes the staged code on to the analog section while that channel's load strobe is low. Both output codes are driven out as 12-bit words. A code N stands for N millivolts at the analog output.

The block is a clocked equivalent of a latch-based interface. Every bus pin passes through a two-flop synchronizer. Reset asserts asynchronously and releases synchronously. A small write-tracking state machine decides which staging register follows the bus. Its states are `ST_RESET` (held while reset is active), `ST_IDLE` (chip select high), `ST_WR_A` and `ST_WR_B` (chip select low with select 0 or 1). Its transitions are: `ST_RESET` to `ST_IDLE` on the first clock after release. `ST_IDLE` goes to `ST_WR_A` or `ST_WR_B` when chip select falls, and the select bit picks which. The two write states switch between each other when the select bit changes while chip select stays low. Either write state returns to `ST_IDLE` when chip select rises. Tying both strobes together stages two codes one at a time and then changes both outputs at once.

Top module: `dacreg_dual`

## Requirements
- R1: While reset is low with the preset select low, both staging registers and both output registers of both channels hold 0x000.
- R2: While reset is low with the preset select high, all four registers hold 0x800 (midscale).
- R3: With chip select low, select value 0 routes the bus into the channel A staging register and value 1 into channel B. The other channel's staging register is left unchanged.
- R4: After chip select rises, the staging register keeps the last code taken from the bus, and later bus changes have no effect on it.
- R5: While a channel's load strobe is low, its output register follows its staging register. While the strobe is high, the output register keeps its value.
- R6: When both load strobes fall on the same clock, the two outputs change in the same clock cycle.
- R7: With a load strobe held low and chip select low on that channel, the output follows the data bus directly. A new bus code appears at the output within 5 clock edges.
- R8: After reset is released, every register keeps its preset value until later chip-select or load activity. The state machine leaves `ST_RESET` for `ST_IDLE` on the first clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_n_i | input | 1 | Active-low reset, asynchronous assert |
| preset_mid_i | input | 1 | Reset preset: 0 gives 0x000, 1 gives 0x800 |
| cs_n_i | input | 1 | Active-low chip select |
| ch_sel_i | input | 1 | Channel select: 0 = A, 1 = B |
| data_i | input | 12 | Code on the parallel bus |
| load_a_n_i | input | 1 | Active-low load strobe, channel A |
| load_b_n_i | input | 1 | Active-low load strobe, channel B |
| dac_a_o | output | 12 | Output register, channel A |
| dac_b_o | output | 12 | Output register, channel B |

## Verification
The bench tests the paths a wrong design would mishandle:
- A write to one channel must leave the other staging register untouched. A swapped select decode would show up as a code on the wrong output after the next load.
- The bus is changed after chip select rises, and the new code must not be captured. A design that captures data late would pick up that junk code.
- A joint load of both channels must update both outputs in the same cycle. A design that skewed the strobes would show one output moving first.
- Reset is applied with both preset values. Loads then follow with no write in between, which shows whether the staging registers were preset as well as the output registers.
- With a strobe held low, the test streams codes straight from the bus to the output, which checks the transparent path and its latency.
- Long randomized mixes of writes, single loads, joint loads and resets are compared against a truth-table model.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WR_A  = 2'd2,
        ST_WR_B  = 2'd3
    } wr_state_e;
endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dacreg_wrfsm.sv
module dacreg_wrfsm
    import dacreg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         preset_mid_i,
    input  logic         cs_n_i,
    input  logic         sel_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] stage_a_o,
    output logic [W-1:0] stage_b_o
);
    wr_state_e    state_q, state_d;
    logic [W-1:0] data_q;
    logic [W-1:0] preset_val;

    assign preset_val = {preset_mid_i, {(W-1){1'b0}}};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_IDLE;
            ST_IDLE:  if (!cs_n_i) state_d = sel_i ? ST_WR_B : ST_WR_A;
            ST_WR_A,
            ST_WR_B:  begin
                if (cs_n_i) state_d = ST_IDLE;
                else        state_d = sel_i ? ST_WR_B : ST_WR_A;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_RESET;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            data_q    <= '0;
            stage_a_o <= preset_val;
            stage_b_o <= preset_val;
        end else begin
            data_q <= data_i;
            unique case (state_q)
                ST_WR_A: stage_a_o <= data_q;
                ST_WR_B: stage_b_o <= data_q;
                default: ;
            endcase
        end
    end

    AST_IDLE_HOLDS_STAGES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_IDLE) |=> ($stable(stage_a_o) && $stable(stage_b_o))); // R4
    AST_WR_A_SPARES_B: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_WR_A) |=> $stable(stage_b_o)); // R3
    AST_WR_B_SPARES_A: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_WR_B) |=> $stable(stage_a_o)); // R3
    AST_RESET_EXIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_RESET) |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/dacreg_outstage.sv
module dacreg_outstage #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         preset_mid_i,
    input  logic         load_n_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] dac_o
);
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)      dac_o <= {preset_mid_i, {(W-1){1'b0}}};
        else if (!load_n_i) dac_o <= src_i;
    end

    AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_n_i |=> $stable(dac_o)); // R5
    AST_LOAD_LOW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_n_i |=> (dac_o == $past(src_i))); // R5
endmodule

// File: rtl/dacreg_dual.sv
module dacreg_dual #(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              preset_mid_i,
    input  logic              cs_n_i,
    input  logic              ch_sel_i,
    input  logic [CODE_W-1:0] data_i,
    input  logic              load_a_n_i,
    input  logic              load_b_n_i,
    output logic [CODE_W-1:0] dac_a_o,
    output logic [CODE_W-1:0] dac_b_o
);
    localparam int NUM_CH = 2;
    localparam int PIN_W  = CODE_W + 2 + NUM_CH;
    localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b0, {NUM_CH{1'b1}}, {CODE_W{1'b0}}};

    logic              rst_int_n;
    logic [PIN_W-1:0]  pins_s;
    logic              cs_n_s, sel_s;
    logic [NUM_CH-1:0] load_n_s;
    logic [CODE_W-1:0] data_s;
    logic [CODE_W-1:0] stage [NUM_CH];
    logic [CODE_W-1:0] dac   [NUM_CH];

    dacreg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .d_i     (1'b1),
        .q_o     (rst_int_n)
    );

    dacreg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_int_n),
        .d_i     ({cs_n_i, ch_sel_i, load_b_n_i, load_a_n_i, data_i}),
        .q_o     (pins_s)
    );

    assign {cs_n_s, sel_s, load_n_s, data_s} = pins_s;

    dacreg_wrfsm #(.W(CODE_W)) u_wrfsm (
        .clk_i        (clk_i),
        .rst_n_i      (rst_int_n),
        .preset_mid_i (preset_mid_i),
        .cs_n_i       (cs_n_s),
        .sel_i        (sel_s),
        .data_i       (data_s),
        .stage_a_o    (stage[0]),
        .stage_b_o    (stage[1])
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
        dacreg_outstage #(.W(CODE_W)) u_out (
            .clk_i        (clk_i),
            .rst_n_i      (rst_int_n),
            .preset_mid_i (preset_mid_i),
            .load_n_i     (load_n_s[ch]),
            .src_i        (stage[ch]),
            .dac_o        (dac[ch])
        );
    end

    assign dac_a_o = dac[0];
    assign dac_b_o = dac[1];

    AST_JOINT_LOAD_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_int_n)
        (load_n_s == '0 && stage[0] != dac[0] && stage[1] != dac[1])
        |=> (dac_a_o != $past(dac_a_o) && dac_b_o != $past(dac_b_o))); // R6
endmodule

// File: tb/dacreg_dual_bench.sv
module dacreg_dual_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n, preset, cs_n, sel, ld_a_n, ld_b_n;
    logic [W-1:0] data;
    logic [W-1:0] dac_a, dac_b;

    typedef struct {
        string        tag;
        logic [W-1:0] ea;
        logic [W-1:0] eb;
    } exp_t;

    exp_t         sb_q [$];
    int           vectors = 0;
    int           fails   = 0;
    logic [W-1:0] m_stage [2];
    logic [W-1:0] m_dac   [2];
    bit           transp  [2];

    always #10 clk = ~clk;

    dacreg_dual u_dacreg_dual (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .preset_mid_i (preset),
        .cs_n_i       (cs_n),
        .ch_sel_i     (sel),
        .data_i       (data),
        .load_a_n_i   (ld_a_n),
        .load_b_n_i   (ld_b_n),
        .dac_a_o      (dac_a),
        .dac_b_o      (dac_b)
    );

    task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares both outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check(it.tag, {dac_a, dac_b}, {it.ea, it.eb});
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(string tag);
        exp_t it;
        it.tag = tag; it.ea = m_dac[0]; it.eb = m_dac[1];
        sb_q.push_back(it);
        cycles(2);
    endtask

    task automatic do_reset(bit p, string tag);
        @(negedge clk);
        preset = p;
        rst_n  = 1'b0;
        cycles(3);
        rst_n  = 1'b1;
        for (int c = 0; c < 2; c++) begin
            m_stage[c] = {p, 11'b0};
            m_dac[c]   = {p, 11'b0};
        end
        cycles(8);
        push(tag);
    endtask

    task automatic do_write(int ch, logic [W-1:0] d, string tag);
        @(negedge clk);
        sel  = ch[0];
        data = d;
        @(negedge clk);
        cs_n = 1'b0;
        cycles(4);
        cs_n = 1'b1;
        cycles(4);
        data = ~d ^ 12'h5A5;          // later bus activity must be ignored (R4)
        m_stage[ch] = d;
        if (transp[ch]) m_dac[ch] = d;
        cycles(8);
        push(tag);
    endtask

    task automatic do_load(bit la, bit lb, string tag);
        @(negedge clk);
        if (la) ld_a_n = 1'b0;
        if (lb) ld_b_n = 1'b0;
        cycles(4);
        ld_a_n = transp[0] ? 1'b0 : 1'b1;
        ld_b_n = transp[1] ? 1'b0 : 1'b1;
        if (la) m_dac[0] = m_stage[0];
        if (lb) m_dac[1] = m_stage[1];
        cycles(6);
        push(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] oa, ob;
        int           moved;
        rst_n = 1'b1; preset = 1'b0; cs_n = 1'b1; sel = 1'b0;
        ld_a_n = 1'b1; ld_b_n = 1'b1; data = '0;
        transp[0] = 0; transp[1] = 0;
        #5;

        // R1: zero preset on both outputs, then staging registers via a joint load
        do_reset(1'b0, "R1 reset zero");
        do_load(1, 1, "R1 staging preset zero");

        // R3 / R4: staged writes stay hidden until a load
        do_write(0, 12'hABC, "R4 write A hidden");
        do_write(1, 12'h123, "R3 write B hidden");
        do_load(1, 0, "R3 load A only");
        do_load(0, 1, "R3 load B only");
        do_write(0, 12'h0F0, "R3 rewrite A");
        do_load(0, 1, "R5 load B leaves A");
        do_load(1, 0, "R5 load A");

        // R6: stage both, drop both strobes on the same edge, watch outputs move together
        do_write(0, 12'h555, "R6 stage A");
        do_write(1, 12'hAAA, "R6 stage B");
        @(negedge clk);
        oa = dac_a; ob = dac_b;
        ld_a_n = 1'b0; ld_b_n = 1'b0;
        moved = 0;
        for (int c = 0; c < 12 && moved == 0; c++) begin
            @(negedge clk);
            if (dac_a != oa || dac_b != ob) begin
                moved = 1;
                check("R6 joint edge", {dac_a, dac_b}, {12'h555, 12'hAAA});
            end
        end
        if (moved == 0) check("R6 joint no move", {dac_a, dac_b}, {12'h555, 12'hAAA});
        ld_a_n = 1'b1; ld_b_n = 1'b1;
        m_dac[0] = 12'h555; m_dac[1] = 12'hAAA;
        cycles(4);

        // R7: load A held low, chip select low, bus streams to output
        @(negedge clk);
        ld_a_n = 1'b0; sel = 1'b0; data = 12'h321;
        @(negedge clk);
        cs_n = 1'b0;
        cycles(6);
        check("R7 direct path first", {dac_a, dac_b}, {12'h321, 12'hAAA});
        data = 12'hFFF;
        cycles(5);
        check("R7 direct path latency", {dac_a, dac_b}, {12'hFFF, 12'hAAA});
        cs_n = 1'b1;
        cycles(4);
        ld_a_n = 1'b1;
        m_stage[0] = 12'hFFF; m_dac[0] = 12'hFFF;
        cycles(4);
        push("R7 after release");

        // R2 / R8: midscale preset held after release, staging preset too
        do_reset(1'b1, "R2 reset midscale");
        cycles(10);
        push("R8 preset held");
        do_load(1, 1, "R8 staging preset mid");
        do_write(1, 12'h7FF, "R3 write B after reset");
        do_load(0, 1, "R5 load B 7FF");

        // randomized mix against the truth-table model
        for (int k = 0; k < 220; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5)       do_write(op % 2, W'($urandom), "R3 rand write");
            else if (op < 7)  do_load(op == 5, op == 6, "R5 rand load");
            else if (op < 9)  do_load(1, 1, "R6 rand joint");
            else              do_reset(1'($urandom), "R8 rand reset");
        end

        wait (sb_q.size() == 0);
        cycles(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule